// File: doc/BRIEF.md
# Picture-Bus Character and Nametable Bank Mapper

This block sits between the picture-processing bus and two memories: the character ROM and the two-page nametable RAM inside the console. Register writes from the CPU side arrive already qualified as write strobes with a 16-bit address and an 8-bit data byte. From these the block keeps eight character bank numbers and four nametable page bits. Every picture-bus address is then translated into a character ROM address or a nametable RAM page line.

Each 1 KiB character window has a bank number assembled from two separately written registers. A 4-bit low part is written with address bit 10 clear and takes the low data nibble. A high part is written with address bit 10 set and takes the upper data nibble. Four quadrant registers, one per nametable, select which RAM page serves that quadrant. Register updates are clocked. The address translation is purely combinational, so a new picture-bus address maps in the same cycle.

Top module: `ppu_bank_map`

## Requirements
- R1: After reset, window i (0..7) has bank number i, and the quadrant bits are 0,1,0,1 for quadrants 0..3 (vertical arrangement), so nt_pages reads 4'b1010.
- R2: A write whose address bits 15:12 are 0xB, 0xC, 0xD or 0xE and whose bit 10 is 0 stores data bits 3:0 into the low part of the addressed window. The high part of that window is left unchanged.
- R3: A write to those groups with address bit 10 set stores data bits 7:4 into the high part of the addressed window. Data bits 3:0 and the window's low part are left unchanged.
- R4: The window index is twice the group offset plus address bit 11, where the group offset is 0 for 0xB, 1 for 0xC, 2 for 0xD and 3 for 0xE. Address bits 9:0 take no part in the choice.
- R5: A window's 9-bit bank number equals its low part plus its high part times 16.
- R6: While ppu_addr[13] is 0, chr_sel is 1 and chr_addr equals {bank of window ppu_addr[12:10], ppu_addr[9:0]}. While ppu_addr[13] is 1, chr_sel is 0.
- R7: A write whose address bits 15:12 are 0x9, bits 11:10 are 2'b11 and bit 2 is 1 stores data bit 0 into quadrant register addr[1:0].
- R8: The following leave every bank number and quadrant bit unchanged: a write in group 0x9 with bit 2 clear or with bits 11:10 other than 2'b11, writes to groups 0x8, 0xA and 0xF, and any cycle with cpu_wr_en low.
- R9: For ppu_addr in 0x2000..0x3EFF, ciram_sel is 1 and ciram_page equals quadrant bit ppu_addr[11:10]. For any other address, ciram_sel and ciram_page are 0.
- R10: A register write shows at the outputs on the first clock edge after the cycle in which cpu_wr_en is high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Register write strobe, one cycle per write |
| cpu_wr_addr | input | 16 | CPU address of the write |
| cpu_wr_data | input | 8 | CPU data of the write |
| ppu_addr | input | 14 | Picture-bus address |
| win_pages | output | 72 | Bank number of each window, window i in bits 9i+8..9i |
| nt_pages | output | 4 | RAM page bit of each nametable quadrant |
| chr_sel | output | 1 | Character ROM selected for the current picture-bus address |
| chr_addr | output | 19 | Character ROM byte address |
| ciram_sel | output | 1 | Nametable RAM selected for the current picture-bus address |
| ciram_page | output | 1 | Nametable RAM page line |

## Verification
A bad nibble steering or window index writes to the wrong window or part. It shows on win_pages, and on chr_addr for that window, one cycle after the write. It stays there until another write repairs it. The bench therefore re-reads every window after each scenario rather than only the one it wrote. A wrong quadrant bit stays hidden until the picture bus fetches from that quadrant, so every quadrant is walked through ciram_page as well as read on nt_pages. Writes that should be ignored are followed by a full comparison of all twelve registers.

// File: rtl/ppu_bank_pkg.sv
package ppu_bank_pkg;

    localparam int CPU_AW    = 16;
    localparam int CPU_DW    = 8;
    localparam int PPU_AW    = 14;
    localparam int CHR_WINS  = 8;
    localparam int NT_QUADS  = 4;
    localparam int LO_W      = 4;
    localparam int HI_W      = 5;
    localparam int PAGE_W    = 9;
    localparam int WIN_OFF_W = 10;
    localparam int WIN_IDX_W = $clog2(CHR_WINS);
    localparam int NT_IDX_W  = $clog2(NT_QUADS);
    localparam int CHR_AW    = PAGE_W + WIN_OFF_W;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_CHR_LO,
        WR_CHR_HI,
        WR_QUAD
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e               kind;
        logic [WIN_IDX_W-1:0]   win;
        logic [NT_IDX_W-1:0]    quad;
        logic [HI_W-1:0]        value;
    } wr_cmd_t;

    typedef struct packed {
        logic                chr_sel;
        logic [CHR_AW-1:0]   chr_addr;
        logic                ciram_sel;
        logic                ciram_page;
    } ppu_map_t;

    // Classify one CPU write and pick the nibble that will be stored.
    function automatic wr_cmd_t decode_write(input logic en,
                                             input logic [CPU_AW-1:0] addr,
                                             input logic [CPU_DW-1:0] data);
        wr_cmd_t    c;
        logic [1:0] grp_off;
        c.kind  = WR_NONE;
        c.win   = '0;
        c.quad  = '0;
        c.value = '0;
        // 0xB..0xE minus 3 in two-bit arithmetic gives 0..3
        grp_off = addr[13:12] - 2'd3;
        if (en) begin
            if (addr[15:12] >= 4'hB && addr[15:12] <= 4'hE) begin
                c.kind  = addr[10] ? WR_CHR_HI : WR_CHR_LO;
                c.win   = {grp_off, addr[11]};
                c.value = addr[10] ? HI_W'(data[7:4]) : HI_W'(data[3:0]);
            end else if (addr[15:12] == 4'h9 && addr[11:10] == 2'b11 && addr[2]) begin
                c.kind  = WR_QUAD;
                c.quad  = addr[1:0];
                c.value = HI_W'(data[0]);
            end
        end
        return c;
    endfunction

    function automatic logic [PAGE_W-1:0] join_page(input logic [LO_W-1:0] lo,
                                                    input logic [HI_W-1:0] hi);
        return (PAGE_W'(hi) << LO_W) | PAGE_W'(lo);
    endfunction

endpackage

// File: rtl/ppu_wr_decode.sv
module ppu_wr_decode
    import ppu_bank_pkg::*;
#(
    parameter int WINS  = CHR_WINS,
    parameter int QUADS = NT_QUADS
) (
    input  logic                 wr_en,
    input  logic [CPU_AW-1:0]    wr_addr,
    input  logic [CPU_DW-1:0]    wr_data,
    output logic [WINS-1:0]      lo_we,
    output logic [WINS-1:0]      hi_we,
    output logic [QUADS-1:0]     quad_we,
    output logic [HI_W-1:0]      wr_value
);
    wr_cmd_t cmd;

    always_comb cmd = decode_write(wr_en, wr_addr, wr_data);

    assign wr_value = cmd.value;

    for (genvar w = 0; w < WINS; w++) begin : g_win_we
        assign lo_we[w] = (cmd.kind == WR_CHR_LO) && (cmd.win == WIN_IDX_W'(w));
        assign hi_we[w] = (cmd.kind == WR_CHR_HI) && (cmd.win == WIN_IDX_W'(w));
    end

    for (genvar q = 0; q < QUADS; q++) begin : g_quad_we
        assign quad_we[q] = (cmd.kind == WR_QUAD) && (cmd.quad == NT_IDX_W'(q));
    end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import ppu_bank_pkg::*;
#(
    parameter int WINS = CHR_WINS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [WINS-1:0]          lo_we,
    input  logic [WINS-1:0]          hi_we,
    input  logic [HI_W-1:0]          wr_value,
    output logic [WINS*PAGE_W-1:0]   pages
);
    for (genvar w = 0; w < WINS; w++) begin : g_win
        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= LO_W'(w);
                hi_q <= '0;
            end else begin
                if (lo_we[w]) lo_q <= wr_value[LO_W-1:0];
                if (hi_we[w]) hi_q <= wr_value;
            end
        end

        assign pages[w*PAGE_W +: PAGE_W] = join_page(lo_q, hi_q);
    end
endmodule

// File: rtl/nt_quad_regs.sv
module nt_quad_regs
    import ppu_bank_pkg::*;
#(
    parameter int QUADS = NT_QUADS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [QUADS-1:0]   quad_we,
    input  logic               wr_bit,
    output logic [QUADS-1:0]   quad_page
);
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        always_ff @(posedge clk) begin
            if (rst)
                quad_page[q] <= 1'(q % 2);
            else if (quad_we[q])
                quad_page[q] <= wr_bit;
        end
    end
endmodule

// File: rtl/ppu_addr_xlate.sv
module ppu_addr_xlate
    import ppu_bank_pkg::*;
#(
    parameter int WINS  = CHR_WINS,
    parameter int QUADS = NT_QUADS
) (
    input  logic [PPU_AW-1:0]        ppu_addr,
    input  logic [WINS*PAGE_W-1:0]   pages,
    input  logic [QUADS-1:0]         quad_page,
    output ppu_map_t                 map
);
    localparam int WIN_SEL_W = $clog2(WINS);
    localparam int Q_SEL_W   = $clog2(QUADS);

    logic [WIN_SEL_W-1:0] win_sel;
    logic [Q_SEL_W-1:0]   quad_sel;
    logic [PAGE_W-1:0]    page;
    logic                 in_nt;

    assign win_sel  = ppu_addr[WIN_OFF_W +: WIN_SEL_W];
    assign quad_sel = ppu_addr[WIN_OFF_W +: Q_SEL_W];
    assign page     = pages[win_sel*PAGE_W +: PAGE_W];
    // nametable space ends where the palette page 0x3F00 begins
    assign in_nt    = ppu_addr[PPU_AW-1] && (ppu_addr[12:8] != 5'h1F);

    always_comb begin
        map.chr_sel    = !ppu_addr[PPU_AW-1];
        map.chr_addr   = {page, ppu_addr[WIN_OFF_W-1:0]};
        map.ciram_sel  = in_nt;
        map.ciram_page = in_nt && quad_page[quad_sel];
    end
endmodule

// File: rtl/ppu_bank_map.sv
module ppu_bank_map
    import ppu_bank_pkg::*;
#(
    parameter int WINS  = CHR_WINS,
    parameter int QUADS = NT_QUADS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_wr_en,
    input  logic [CPU_AW-1:0]        cpu_wr_addr,
    input  logic [CPU_DW-1:0]        cpu_wr_data,
    input  logic [PPU_AW-1:0]        ppu_addr,
    output logic [WINS*PAGE_W-1:0]   win_pages,
    output logic [QUADS-1:0]         nt_pages,
    output logic                     chr_sel,
    output logic [CHR_AW-1:0]        chr_addr,
    output logic                     ciram_sel,
    output logic                     ciram_page
);
    logic [WINS-1:0]  lo_we;
    logic [WINS-1:0]  hi_we;
    logic [QUADS-1:0] quad_we;
    logic [HI_W-1:0]  wr_value;
    ppu_map_t         map;

    ppu_wr_decode #(.WINS(WINS), .QUADS(QUADS)) u_dec (
        .wr_en    (cpu_wr_en),
        .wr_addr  (cpu_wr_addr),
        .wr_data  (cpu_wr_data),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .quad_we  (quad_we),
        .wr_value (wr_value)
    );

    chr_bank_regs #(.WINS(WINS)) u_chr (
        .clk      (clk),
        .rst      (rst),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .wr_value (wr_value),
        .pages    (win_pages)
    );

    nt_quad_regs #(.QUADS(QUADS)) u_nt (
        .clk       (clk),
        .rst       (rst),
        .quad_we   (quad_we),
        .wr_bit    (wr_value[0]),
        .quad_page (nt_pages)
    );

    ppu_addr_xlate #(.WINS(WINS), .QUADS(QUADS)) u_xl (
        .ppu_addr  (ppu_addr),
        .pages     (win_pages),
        .quad_page (nt_pages),
        .map       (map)
    );

    assign chr_sel    = map.chr_sel;
    assign chr_addr   = map.chr_addr;
    assign ciram_sel  = map.ciram_sel;
    assign ciram_page = map.ciram_page;
endmodule

// File: rtl/ppu_bank_map_chk.sv
module ppu_bank_map_chk
    import ppu_bank_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         cpu_wr_en,
    input logic [CPU_AW-1:0]            cpu_wr_addr,
    input logic [CPU_DW-1:0]            cpu_wr_data,
    input logic [PPU_AW-1:0]            ppu_addr,
    input logic [CHR_WINS*PAGE_W-1:0]   win_pages,
    input logic [NT_QUADS-1:0]          nt_pages,
    input logic                         chr_sel,
    input logic [CHR_AW-1:0]            chr_addr,
    input logic                         ciram_sel,
    input logic                         ciram_page
);
    logic       in_chr_grp;
    logic [2:0] tgt_win;

    assign in_chr_grp = cpu_wr_addr[15:12] >= 4'hB && cpu_wr_addr[15:12] <= 4'hE;
    assign tgt_win    = 3'((cpu_wr_addr[14:12] - 3'd3) * 2) + 3'(cpu_wr_addr[11]);

    for (genvar w = 0; w < CHR_WINS; w++) begin : g_win_chk
        // R2
        lo_nibble_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_wr_en && in_chr_grp && !cpu_wr_addr[10] && tgt_win == 3'(w))
            |=> win_pages[w*PAGE_W +: LO_W] == $past(cpu_wr_data[3:0]));
        // R3
        hi_nibble_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_wr_en && in_chr_grp && cpu_wr_addr[10] && tgt_win == 3'(w))
            |=> win_pages[w*PAGE_W + LO_W +: HI_W] == {1'b0, $past(cpu_wr_data[7:4])});
    end

    for (genvar q = 0; q < NT_QUADS; q++) begin : g_quad_chk
        // R7
        quad_write_chk: assert property (@(posedge clk) disable iff (rst)
            (cpu_wr_en && cpu_wr_addr[15:10] == 6'b1001_11 && cpu_wr_addr[2]
             && cpu_wr_addr[1:0] == 2'(q))
            |=> nt_pages[q] == $past(cpu_wr_data[0]));
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr_en |=> $stable(win_pages) && $stable(nt_pages));

    // R6
    chr_map_chk: assert property (@(posedge clk) disable iff (rst)
        !ppu_addr[13] |-> chr_sel && !ciram_sel
            && chr_addr == {win_pages[ppu_addr[12:10]*PAGE_W +: PAGE_W], ppu_addr[9:0]});

    // R9
    nt_map_chk: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13] && ppu_addr[12:8] != 5'h1F)
            |-> !chr_sel && ciram_sel && ciram_page == nt_pages[ppu_addr[11:10]]);

    // R9
    palette_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ppu_addr[13:8] == 6'h3F) |-> !ciram_sel && !ciram_page && !chr_sel);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> nt_pages == 4'b1010 && win_pages[PAGE_W +: PAGE_W] == 9'd1);
endmodule

bind ppu_bank_map ppu_bank_map_chk i_chk (.*);

// File: tb/test_ppu_bank_map.sv
module test_ppu_bank_map;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_wr_addr = '0;
    logic [7:0]  cpu_wr_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [71:0] win_pages;
    logic [3:0]  nt_pages;
    logic        chr_sel;
    logic [18:0] chr_addr;
    logic        ciram_sel;
    logic        ciram_page;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_page [8];
    logic       exp_quad [4];

    always #2 clk = ~clk;

    ppu_bank_map i_ppu_bank_map (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CPU address of window w, part hi (R4); junk fills bits 9:0
    function automatic logic [15:0] chr_reg_addr(input int w, input bit hi, input logic [9:0] junk);
        return 16'hB000 + 16'((w / 2) << 12) + 16'((w % 2) << 11) + 16'(hi << 10) + 16'(junk);
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 8; w++)
            chk(req, 32'(win_pages[w*9 +: 9]), 32'(exp_page[w]));
        for (int q = 0; q < 4; q++)
            chk(req, 32'(nt_pages[q]), 32'(exp_quad[q]));
    endtask

    task automatic t_reset;
        for (int w = 0; w < 8; w++) exp_page[w] = 9'(w);
        for (int q = 0; q < 4; q++) exp_quad[q] = 1'(q % 2);
        check_all("R1");
        chk("R1", 32'(nt_pages), 32'hA);
    endtask

    task automatic t_lo_writes;
        for (int w = 0; w < 8; w++) begin
            cpu_write(chr_reg_addr(w, 1'b0, 10'(w * 37)), 8'(8'hA0 | (15 - w)));
            exp_page[w][3:0] = 4'(15 - w);
        end
        check_all("R2");
    endtask

    task automatic t_hi_writes;
        for (int w = 0; w < 8; w++) begin
            cpu_write(chr_reg_addr(w, 1'b1, 10'h3FB), 8'(((w + 8) << 4) | 5));
            exp_page[w] = 9'(((w + 8) << 4) | (15 - w));
        end
        check_all("R3");
        chk("R5", 32'(win_pages[7*9 +: 9]), 32'h0F8);
    endtask

    task automatic t_timing;
        // R10: not visible in the write cycle, visible after the edge
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wr_addr = chr_reg_addr(5, 1'b0, 10'h0); cpu_wr_data = 8'h03;
        #1 chk("R10", 32'(win_pages[5*9 +: 9]), 32'(exp_page[5]));
        @(negedge clk);
        cpu_wr_en = 1'b0;
        exp_page[5][3:0] = 4'h3;
        chk("R10", 32'(win_pages[5*9 +: 9]), 32'(exp_page[5]));
    endtask

    task automatic t_ignored;
        cpu_write(16'h8000, 8'hFF);
        cpu_write(16'hA003, 8'hFF);
        cpu_write(16'hF000, 8'hFF);
        cpu_write(16'hF003, 8'hFF);
        cpu_write(16'h9000, 8'hFF);
        cpu_write(16'h9007, 8'hFF);
        cpu_write(16'h9803, 8'hFF);
        cpu_write(16'h9C03, 8'hFF);
        @(negedge clk);
        cpu_wr_addr = chr_reg_addr(0, 1'b0, 10'h0); cpu_wr_data = 8'hEE;
        @(negedge clk);
        check_all("R8");
    endtask

    task automatic t_quads;
        cpu_write(16'h9C04, 8'hFE); exp_quad[0] = 1'b0;
        cpu_write(16'h9C05, 8'h00); exp_quad[1] = 1'b0;
        cpu_write(16'h9C06, 8'h01); exp_quad[2] = 1'b1;
        cpu_write(16'h9C07, 8'h03); exp_quad[3] = 1'b1;
        check_all("R7");
        cpu_write(16'h9C05, 8'h81); exp_quad[1] = 1'b1;
        cpu_write(16'h9C06, 8'h80); exp_quad[2] = 1'b0;
        check_all("R7");
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            ppu_addr = 14'h2000 + 14'(q << 10) + 14'h155;
            #1;
            chk("R9", 32'({ciram_sel, ciram_page, chr_sel}), 32'({1'b1, exp_quad[q], 1'b0}));
            ppu_addr = 14'h3000 + 14'(q << 10) + 14'h0AA;
            #1;
            if (q < 3)
                chk("R9", 32'({ciram_sel, ciram_page}), 32'({1'b1, exp_quad[q]}));
        end
        ppu_addr = 14'h3EFF; #1;
        chk("R9", 32'({ciram_sel, ciram_page}), 32'({1'b1, exp_quad[3]}));
        ppu_addr = 14'h3F00; #1;
        chk("R9", 32'({ciram_sel, ciram_page, chr_sel}), 32'b000);
        ppu_addr = 14'h1FFF; #1;
        chk("R9", 32'({ciram_sel, ciram_page}), 32'b00);
    endtask

    task automatic t_xlate;
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            ppu_addr = 14'(w << 10) | 14'((w * 97) & 10'h3FF);
            #1;
            chk("R6", 32'(chr_sel), 32'h1);
            chk("R6", 32'(chr_addr), 32'({exp_page[w], 10'((w * 97) & 10'h3FF)}));
        end
        ppu_addr = 14'h2400; #1;
        chk("R6", 32'(chr_sel), 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lo_writes();
        t_hi_writes();
        t_timing();
        t_ignored();
        t_quads();
        t_xlate();
        // R1: a second reset restores the initial state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule